// File: doc/BRIEF.md
# SPI Flash Register-Operation Sequencer

This block runs one single-lane SPI flash command transaction each time software sets the start bit of its operation register. Software first programs an 8-bit opcode, a data byte count, a chip-select index, the three chip-select timing counts and the phase enables. The sequencer then lowers the chosen chip select and waits out the setup interval. It shifts out the opcode and, depending on the enables, either sends bytes from a 64-byte internal buffer or captures received bytes into that buffer. It then waits out the hold interval, raises chip select and waits out the deselect interval. At that point it sets a sticky done flag.

The serial port works in SPI mode 0, with the most significant bit first. SCLK runs at half the system clock. The buffer is reached through the same register port as the configuration, one byte per word address. A transfer longer than the buffer walks around it modulo 64.

Top module: `spi_flash_regop_seq`

## Requirements
- R1: After reset the timing register (address 0x04) reads 0x66F (hold 6, setup 6, deselect 15), the status register and the operation register read 0, both chip-select outputs are high and SCLK is low.
- R2: The register map uses word addresses. 0x00 holds the opcode in bits 7:0. 0x01 holds a 14-bit byte count in bits 13:0. 0x02 holds the chip-select index in bit 11 only. 0x03 holds the operation bits 8:0. 0x04 holds timing: hold in 11:8, setup in 7:4, deselect in 3:0. 0x05 holds the status, with done in bit 0. 0x06 is the status clear. Addresses 0x40 to 0x7F hold buffer bytes 0 to 63. Unused bits read 0.
- R3: When the command bit (bit 7) is set in an operation started by bit 0, the opcode is the first byte sent. Bits are sent MSB first in mode 0: MOSI is stable while SCLK is high, each SCLK high and low phase lasts one clock, and SCLK toggles only while a chip select is low.
- R4: With the write-data bit (bit 5) set and a nonzero count N, N bytes follow the opcode, taken from buffer offsets 0, 1, 2 and so on, modulo 64. Write-data takes priority over read.
- R5: With the read-data bit (bit 2) or the read-status bit (bit 1) set and count N, N bytes sampled on the rising SCLK edge are stored at buffer offsets 0, 1, 2 and so on, modulo 64, so a later byte overwrites an earlier one. MOSI is held low during these bytes.
- R6: From the clock on which chip select falls to the clock on which SCLK first rises is max(S,1)+1 clocks, where S is the setup count.
- R7: From the last SCLK fall to chip select rising is max(H,1) clocks, where H is the hold count.
- R8: From chip select rising to the done flag reading 1 is max(D,1) clocks, where D is the deselect count. Chip select stays high during that time.
- R9: Writing address 0x06 with bit 0 set clears the done flag. Writing it with bit 0 clear leaves the flag unchanged.
- R10: Operation bit 0 reads 1 while a transaction runs and 0 after it ends. Writes to the operation register while busy have no effect and start nothing.
- R11: A chip-select index of 0 lowers chip-select output bit 0, and an index of 1 lowers bit 1. Never more than one is low at a time.
- R12: A count of 0, or no data enable, sends only the opcode. With the command bit also clear, no SCLK pulse occurs at all, but the setup, hold and deselect intervals and the done flag still take place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 2 | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock (system clock / 2) |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Register reads are combinational, so the bench samples them in the same cycle as the address, half a clock after it changes. The chip-select fall is seen one clock after the start write is sampled. The first SCLK rise follows max(S,1)+1 clocks later. The chip-select rise follows the last SCLK fall by max(H,1) clocks, and done is seen max(D,1) clocks after that. The bench timestamps every SCLK and chip-select edge at falling clock edges and compares the gaps with these formulas. It also rebuilds the expected buffer and the captured MOSI bytes from its own model of the requirements.

// File: rtl/spi_flash_regop_seq.sv
module spi_flash_regop_seq #(
  parameter int BUF_DEPTH = 64,
  parameter int CNT_W     = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [1:0]  spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int BAW = $clog2(BUF_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_DESEL} st_t;
  st_t st;

  logic [7:0]       opcode, sh, rx;
  logic [CNT_W-1:0] cnt, didx;
  logic             csel, done, ph, in_cmd;
  logic [8:0]       op_q;
  logic [11:0]      tim;
  logic [3:0]       tcnt;
  logic [2:0]       bitn;
  logic [7:0]       bufm [BUF_DEPTH];

  wire busy     = (st != S_IDLE);
  wire op_wr    = reg_we && (reg_addr == 7'h03);
  wire go       = op_wr && !busy && reg_wdata[0];
  wire wr_en    = op_q[5];
  wire rd_en    = (op_q[2] | op_q[1]) & ~op_q[5];
  wire dat      = (wr_en | rd_en) && (cnt != '0);
  wire tick_end = (tcnt <= 4'd1);
  wire byte_end = (st == S_SHIFT) && ph && (bitn == 3'd7);
  wire last_dat = (didx + CNT_W'(1)) == cnt;
  wire cap_we   = byte_end && !in_cmd && rd_en;
  wire [BAW-1:0] nidx = didx[BAW-1:0] + BAW'(1);
  wire [7:0] first_dat = wr_en ? bufm[0] : 8'h00;
  wire [7:0] next_dat  = wr_en ? bufm[nidx] : 8'h00;

  assign spi_mosi = (st == S_SHIFT) && sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; ph <= 1'b0; bitn <= '0; sh <= '0; rx <= '0;
      in_cmd <= 1'b0; didx <= '0; spi_sclk <= 1'b0; spi_cs_n <= 2'b11;
      done <= 1'b0; op_q <= '0; opcode <= '0; cnt <= '0; csel <= 1'b0;
      tim <= 12'h66F;
    end else begin
      if (reg_we && !reg_addr[6]) begin
        case (reg_addr[5:0])
          6'h00: opcode <= reg_wdata[7:0];
          6'h01: cnt    <= reg_wdata[CNT_W-1:0];
          6'h02: csel   <= reg_wdata[11];
          6'h03: if (!busy) op_q <= reg_wdata[8:0];
          6'h04: tim    <= reg_wdata[11:0];
          6'h06: if (reg_wdata[0]) done <= 1'b0;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (go) begin
          st <= S_SETUP;
          tcnt <= tim[7:4];
          spi_cs_n <= csel ? 2'b01 : 2'b10;
        end
        S_SETUP: if (tick_end) begin
          ph <= 1'b0; bitn <= '0; didx <= '0;
          if (op_q[7]) begin
            st <= S_SHIFT; in_cmd <= 1'b1; sh <= opcode;
          end else if (dat) begin
            st <= S_SHIFT; in_cmd <= 1'b0; sh <= first_dat;
          end else begin
            st <= S_HOLD; tcnt <= tim[11:8];
          end
        end else tcnt <= tcnt - 4'd1;
        S_SHIFT: if (!ph) begin
          spi_sclk <= 1'b1; ph <= 1'b1; rx <= {rx[6:0], spi_miso};
        end else begin
          spi_sclk <= 1'b0; ph <= 1'b0; bitn <= bitn + 3'd1;
          sh <= {sh[6:0], 1'b0};
          if (bitn == 3'd7) begin
            if (in_cmd) begin
              in_cmd <= 1'b0;
              if (dat) sh <= first_dat;
              else begin st <= S_HOLD; tcnt <= tim[11:8]; end
            end else begin
              didx <= didx + CNT_W'(1);
              if (last_dat) begin st <= S_HOLD; tcnt <= tim[11:8]; end
              else sh <= next_dat;
            end
          end
        end
        S_HOLD: if (tick_end) begin
          st <= S_DESEL; tcnt <= tim[3:0]; spi_cs_n <= 2'b11;
        end else tcnt <= tcnt - 4'd1;
        S_DESEL: if (tick_end) begin
          st <= S_IDLE; done <= 1'b1; op_q[0] <= 1'b0;
        end else tcnt <= tcnt - 4'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cap_we) bufm[didx[BAW-1:0]] <= rx;
    else if (reg_we && reg_addr[6]) bufm[reg_addr[BAW-1:0]] <= reg_wdata[7:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[6]) reg_rdata[7:0] = bufm[reg_addr[BAW-1:0]];
    else case (reg_addr[5:0])
      6'h00: reg_rdata[7:0] = opcode;
      6'h01: reg_rdata[CNT_W-1:0] = cnt;
      6'h02: reg_rdata[11] = csel;
      6'h03: reg_rdata[8:0] = op_q;
      6'h04: reg_rdata[11:0] = tim;
      6'h05: reg_rdata[0] = done;
      default: ;
    endcase
  end

  assert_one_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !(&spi_cs_n));
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  assert_done_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&spi_cs_n) && !spi_sclk);
  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !op_q[0]);
  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_wr) |=> $stable(op_q[8:1]));
endmodule

// File: tb/spi_flash_regop_seq_bench.sv
module spi_flash_regop_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire [31:0] reg_rdata;
  wire [1:0] cs_n;
  wire sclk, mosi;

  spi_flash_regop_seq u_spi_flash_regop_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso));

  always #5 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0, bc = 0;
  int t_csf, t_csr, t_sr1, t_sf, t_done, csf_cnt, rise_cnt;
  logic [1:0] lo;
  logic pcs = 1'b1, psclk = 1'b0;
  logic [7:0] stream [128];
  logic [7:0] cap [128];
  logic [7:0] bm [64];
  bit finished = 0;

  always @(posedge clk) cyc++;
  always_comb miso = stream[(bc >> 3) & 127][7 - (bc & 7)];

  always @(negedge clk) begin
    if (pcs && !(&cs_n)) begin t_csf = cyc; csf_cnt++; bc = 0; end
    if (!pcs && (&cs_n)) t_csr = cyc;
    if (!cs_n[0]) lo[0] = 1'b1;
    if (!cs_n[1]) lo[1] = 1'b1;
    if (!psclk && sclk) begin
      if (rise_cnt == 0) t_sr1 = cyc;
      rise_cnt++;
      cap[(bc >> 3) & 127] = {cap[(bc >> 3) & 127][6:0], mosi};
      bc++;
    end
    if (psclk && !sclk) t_sf = cyc;
    pcs = &cs_n; psclk = sclk;
  end

  function automatic int effc(input int x); return (x == 0) ? 1 : x; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_addr = 7'(a); #1; v = reg_rdata;
  endtask

  task automatic mon_clr();
    t_csf = -1; t_csr = -1; t_sr1 = -1; t_sf = -1; t_done = -1;
    csf_cnt = 0; rise_cnt = 0; lo = 2'b00;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(5, v);
      if (v[0]) begin t_done = cyc; break; end
    end
  endtask

  // mode: 0 write, 1 read, 2 read-status, 3 command only
  task automatic run_op(input int mode, input bit cmd, input int n, input bit sel,
                        input int s, input int h, input int d);
    logic [31:0] v;
    logic [7:0] opc;
    int nb, off, bad, opv;
    opc = 8'($urandom);
    wr(0, opc); wr(1, n); wr(2, sel << 11); wr(4, (h << 8) | (s << 4) | d);
    if (mode == 0)
      for (int i = 0; i < ((n < 64) ? n : 64); i++) begin
        bm[i] = 8'($urandom); wr(64 + i, bm[i]);
      end
    for (int i = 0; i < 128; i++) stream[i] = 8'($urandom);
    wr(6, 'hFF);
    mon_clr();
    opv = (cmd << 7) | 1 | ((mode == 0) ? 32 : (mode == 1) ? 4 : (mode == 2) ? 2 : 0);
    wr(3, opv);
    wait_done();
    off = cmd ? 1 : 0;
    nb = off + ((mode != 3) ? n : 0);
    chk(t_done >= 0, "R8 done seen", t_done, 1);
    chk(bc == 8 * nb, "R3/R12 bit count", bc, 8 * nb);
    if (nb == 0) chk(rise_cnt == 0, "R12 no sclk", rise_cnt, 0);
    if (cmd) chk(cap[0] == opc, "R3 opcode", cap[0], opc);
    chk(lo == (sel ? 2'b10 : 2'b01), "R11 cs line", lo, sel ? 2 : 1);
    chk(csf_cnt == 1, "R11 one frame", csf_cnt, 1);
    if (nb > 0) begin
      chk(t_sr1 - t_csf == effc(s) + 1, "R6 setup", t_sr1 - t_csf, effc(s) + 1);
      chk(t_csr - t_sf == effc(h), "R7 hold", t_csr - t_sf, effc(h));
    end
    chk(t_done - t_csr == effc(d), "R8 deselect", t_done - t_csr, effc(d));
    rd(3, v);
    chk(v[0] == 1'b0, "R10 start self-clear", v[0], 0);
    if (mode == 0) begin
      bad = 0;
      for (int i = 0; i < n; i++) if (cap[off + i] != bm[i % 64]) bad++;
      chk(bad == 0, "R4 write bytes", bad, 0);
    end
    if (mode == 1 || mode == 2) begin
      for (int i = 0; i < n; i++) bm[i % 64] = stream[off + i];
      bad = 0;
      for (int i = 0; i < 64; i++) begin rd(64 + i, v); if (v[7:0] !== bm[i]) bad++; end
      chk(bad == 0, "R5 read buffer", bad, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    for (int i = 0; i < 64; i++) bm[i] = 8'h00;
    for (int i = 0; i < 128; i++) stream[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(4, v); chk(v == 32'h66F, "R1 timing reset", v, 32'h66F);
    rd(5, v); chk(v == 0, "R1 done reset", v, 0);
    rd(3, v); chk(v == 0, "R1 op reset", v, 0);
    chk(cs_n == 2'b11 && sclk == 1'b0, "R1 pins", {cs_n, sclk}, 6);
    for (int i = 0; i < 64; i++) wr(64 + i, 0);
    wr(1, -1); rd(1, v); chk(v == 32'h3FFF, "R2 count width", v, 32'h3FFF);
    wr(2, -1); rd(2, v); chk(v == 32'h800, "R2 cs field", v, 32'h800);
    wr(0, -1); rd(0, v); chk(v == 32'hFF, "R2 opcode field", v, 32'hFF);
    wr(2, 0);

    run_op(0, 1, 3, 0, 6, 6, 15);
    run_op(3, 1, 0, 1, 2, 3, 4);
    run_op(0, 1, 0, 0, 1, 1, 1);
    run_op(3, 0, 0, 0, 2, 3, 4);
    run_op(1, 1, 70, 1, 0, 0, 0);
    run_op(0, 0, 68, 0, 1, 15, 1);
    run_op(2, 1, 5, 1, 15, 2, 7);

    rd(5, v); chk(v[0] == 1'b1, "R9 done sticky", v, 1);
    wr(6, 'hFE); rd(5, v); chk(v[0] == 1'b1, "R9 zero bit keeps", v, 1);
    wr(6, 1); rd(5, v); chk(v[0] == 1'b0, "R9 clear", v, 0);

    wr(1, 12); wr(4, 'h333); wr(2, 0);
    mon_clr();
    wr(3, 'h0A1);
    rd(3, v); chk(v[0] == 1'b1, "R10 busy start", v, 1);
    wr(3, 'h1C7);
    wait_done();
    rd(3, v); chk(v == 32'h0A0, "R10 busy write ignored", v, 32'h0A0);
    repeat (40) @(negedge clk);
    chk(csf_cnt == 1 && (&cs_n), "R10 no second start", csf_cnt, 1);

    for (int k = 0; k < 20; k++)
      run_op($urandom_range(0, 3), 1'($urandom_range(0, 3) != 0), $urandom_range(0, 70),
             1'($urandom), $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule